// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 16-bit successive-approximation converter. When the convert input rises, it starts a binary search. The search drives a trial code to an external DAC and comparator. Each step it reads back one comparator bit, which is high when the sampled input is at or above the trial level. For the whole search it holds a busy flag. At the end it places the final code in a held result register and drops back into a low-power idle state. A separate serial readout block reads the result while the converter sleeps.

Each search step lasts a parameterised number of clock cycles, so the conversion length is `WIDTH*STEP_CYCLES` cycles. With the defaults at 50 MHz this is 128 cycles, or 2.56 µs, which is inside a 3 µs conversion budget. After reset, a hold-off counter blocks conversions for `HOLDOFF_CYCLES` cycles, which is 20 µs by default.

The result is a held register, not a stream. It has no valid/ready handshake and the reader cannot apply back-pressure. The code stays put until the next conversion completes. The convert and status pins are plain levels.

Top module: `sar_sequencer`

## Requirements
- R1: While reset is held, and directly after it: busy is 0, power-down is 1, the trial code is 0 and the result is 0.
- R2: A conversion starts on a clock edge where convert is sampled 1 and was 0 at the previous edge, provided the block is idle and the hold-off has elapsed. Busy is 1 from the following cycle.
- R3: In the first cycle of a conversion the trial code is only the MSB: 0x8000.
- R4: Each step lasts STEP_CYCLES cycles and ends by deciding one bit. The tested bit keeps the comparator value, and the next lower bit is set to 1. After step s, bits above position 15-s equal the input's bits.
- R5: Busy stays 1 for exactly WIDTH*STEP_CYCLES cycles.
- R6: Convert rising edges seen while busy are ignored. The running conversion neither restarts nor lengthens, and its result is unchanged.
- R7: The result register changes only in the cycle in which busy falls. It takes its full new value at once and holds it while idle.
- R8: The output is straight binary. An input of 0 yields 0x0000 and an input of full scale minus one LSB yields 0xFFFF.
- R9: Convert edges in the first HOLDOFF_CYCLES clock edges after reset release are rejected. Busy stays 0 and power-down stays 1.
- R10: A convert level held high does not start a second conversion. Only a fresh rising edge does.
- R11: Power-down is 1 exactly when busy is 0. The trial code is 0 while powered down.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, treated as power-on reset |
| cnv_i | input | 1 | Convert request; the rising edge starts a conversion |
| cmp_i | input | 1 | Comparator result: 1 when input >= trial level |
| trial_o | output | 16 | Trial code driven to the DAC |
| busy_o | output | 1 | High while a conversion runs |
| pd_o | output | 1 | High while idle / powered down |
| result_o | output | 16 | Last completed conversion code |

## Verification
The bench aims at the following corner cases:
- **Extreme codes.** Conversions at 0 and at 0xFFFF catch a search that mishandles its first or last bit: it would return 0x0001, 0x7FFF or a code with bit 0 stuck.
- **Extra edges.** Convert pulses during a running conversion, and a convert level held high across its end, would show up as a lengthened busy, a second busy period or a result taken from a restarted search.
- **Hold-off window.** A request inside the window after reset must leave busy low. A design that starts early would raise busy.
- **Result timing.** Comparing the result on every cycle against a behavioural model exposes any update made before busy falls, or one spread over several cycles.

// File: rtl/sar_pkg.sv
package sar_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_CONV = 1'b1
  } sar_state_e;
endpackage

// File: rtl/sar_holdoff.sv
// Counts clock edges after reset release; ready once the window is over.
module sar_holdoff #(
  parameter int HOLDOFF_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  output logic ready_o
);
  generate
    if (HOLDOFF_CYCLES == 0) begin : g_none
      assign ready_o = 1'b1;
    end else begin : g_cnt
      localparam int CW = $clog2(HOLDOFF_CYCLES + 1);
      localparam logic [CW-1:0] LIMIT = CW'(HOLDOFF_CYCLES);
      logic [CW-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
      end
      assign ready_o = (cnt_q == LIMIT);
    end
  endgenerate
endmodule

// File: rtl/sar_edge_det.sv
// Optional synchroniser followed by a rising-edge detector.
module sar_edge_det #(
  parameter int SYNC_STAGES = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o
);
  logic lvl_s;
  logic prev_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign lvl_s = lvl_i;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[SYNC_STAGES-2+1-1:0], lvl_i} >> 0;
      end
      assign lvl_s = chain_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_s;
  end

  assign rise_o = lvl_s & ~prev_q;
endmodule

// File: rtl/sar_step_timer.sv
// Divides the clock into search steps; flags the last cycle of each step.
module sar_step_timer #(
  parameter int STEP_CYCLES = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic run_i,
  output logic step_end_o
);
  localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEP_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (clear_i)        cnt_q <= '0;
    else if (run_i) begin
      if (cnt_q == LAST)     cnt_q <= '0;
      else                   cnt_q <= cnt_q + 1'b1;
    end
  end

  assign step_end_o = run_i && (cnt_q == LAST);
endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer #(
  parameter int WIDTH          = 16,
  parameter int STEP_CYCLES    = 8,
  parameter int HOLDOFF_CYCLES = 1000,
  parameter int SYNC_STAGES    = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cnv_i,
  input  logic             cmp_i,
  output logic [WIDTH-1:0] trial_o,
  output logic             busy_o,
  output logic             pd_o,
  output logic [WIDTH-1:0] result_o
);
  import sar_pkg::*;

  localparam int IW = (WIDTH > 1) ? $clog2(WIDTH) : 1;
  localparam logic [WIDTH-1:0] MSB_ONLY = {1'b1, {(WIDTH-1){1'b0}}};

  sar_state_e       state_q;
  logic [IW-1:0]    bit_q;
  logic [WIDTH-1:0] trial_q;
  logic [WIDTH-1:0] result_q;
  logic [WIDTH-1:0] trial_next;
  logic             rise;
  logic             ready;
  logic             start;
  logic             step_end;
  logic             conv;

  sar_edge_det #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lvl_i (cnv_i),
    .rise_o(rise)
  );

  sar_holdoff #(.HOLDOFF_CYCLES(HOLDOFF_CYCLES)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .ready_o(ready)
  );

  assign conv  = (state_q == ST_CONV);
  assign start = rise && ready && !conv;

  sar_step_timer #(.STEP_CYCLES(STEP_CYCLES)) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear_i   (start),
    .run_i     (conv),
    .step_end_o(step_end)
  );

  // Decide the bit under test and arm the next lower one.
  always_comb begin
    for (int i = 0; i < WIDTH; i++) begin
      if (bit_q == IW'(i))
        trial_next[i] = cmp_i;
      else if ({1'b0, bit_q} == (IW+1)'(i + 1))
        trial_next[i] = 1'b1;
      else
        trial_next[i] = trial_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      bit_q    <= '0;
      trial_q  <= '0;
      result_q <= '0;
    end else if (start) begin
      state_q <= ST_CONV;
      bit_q   <= IW'(WIDTH - 1);
      trial_q <= MSB_ONLY;
    end else if (conv && step_end) begin
      if (bit_q == '0) begin
        result_q <= trial_next;
        trial_q  <= '0;
        state_q  <= ST_IDLE;
      end else begin
        trial_q <= trial_next;
        bit_q   <= bit_q - 1'b1;
      end
    end
  end

  assign trial_o  = trial_q;
  assign busy_o   = conv;
  assign pd_o     = !conv;
  assign result_o = result_q;
endmodule

// File: rtl/sar_sequencer_chk.sv
module sar_sequencer_chk #(
  parameter int W       = 16,
  parameter int DIV     = 8,
  parameter int HOLDOFF = 1000
) (
  input logic         clk,
  input logic         rst_n,
  input logic         busy_o,
  input logic         pd_o,
  input logic [W-1:0] trial_o,
  input logic [W-1:0] result_o
);
  localparam int TOTAL = W * DIV;

  int blen;
  int hcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blen <= 0;
      hcnt <= 0;
    end else begin
      blen <= busy_o ? blen + 1 : 0;
      if (hcnt < HOLDOFF) hcnt <= hcnt + 1;
    end
  end

  // R5: busy length is exact
  a_r5_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> blen == TOTAL);

  // R6: no restart can stretch a conversion
  a_r6_no_stretch: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> blen < TOTAL);

  // R3: search opens at the MSB
  a_r3_msb_first: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> trial_o == {1'b1, {(W-1){1'b0}}});

  // R4: a bit is always under test during a conversion
  a_r4_trial_live: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> trial_o != '0);

  // R7: result moves only as busy falls
  a_r7_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy_o) |-> $stable(result_o));

  // R9: nothing starts inside the hold-off window
  a_r9_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    (hcnt < HOLDOFF) |-> !busy_o);

  // R11: power-down mirrors idle, trial cleared
  a_r11_pd_idle: assert property (@(posedge clk) disable iff (!rst_n)
    pd_o |-> (!busy_o && trial_o == '0));
  a_r11_pd_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> !pd_o);
endmodule

bind sar_sequencer sar_sequencer_chk #(
  .W(WIDTH), .DIV(STEP_CYCLES), .HOLDOFF(HOLDOFF_CYCLES)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy_o  (busy_o),
  .pd_o    (pd_o),
  .trial_o (trial_o),
  .result_o(result_o)
);

// File: tb/test_sar_sequencer.sv
`timescale 1ns/1ps
module test_sar_sequencer;
  localparam int W     = 16;
  localparam int DIV   = 8;
  localparam int HOLD  = 1000;
  localparam int TOTAL = W * DIV;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cnv = 1'b0;
  logic [W-1:0] vin = '0;
  logic         cmp;
  logic [W-1:0] trial;
  logic         busy;
  logic         pd;
  logic [W-1:0] result;

  int n_chk = 0;
  int n_err = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  // Behavioural comparator: input at or above trial level.
  assign cmp = (vin >= trial);

  sar_sequencer #(.WIDTH(W), .STEP_CYCLES(DIV), .HOLDOFF_CYCLES(HOLD)) i_sar_sequencer (
    .clk(clk), .rst_n(rst_n), .cnv_i(cnv), .cmp_i(cmp),
    .trial_o(trial), .busy_o(busy), .pd_o(pd), .result_o(result)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model
  bit m_busy = 0, m_cnvq = 0;
  int m_off = 0, m_vin = 0, m_result = 0, m_edges = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnvq = 0; m_off = 0; m_result = 0; m_edges = 0;
    end else begin
      if (m_busy) begin
        m_off++;
        if (m_off == TOTAL) begin
          m_busy = 0;
          m_result = m_vin;
        end
      end else if (cnv && !m_cnvq && m_edges >= HOLD) begin
        m_busy = 1; m_off = 0; m_vin = int'(vin);
      end
      m_cnvq = cnv;
      if (m_edges < HOLD) m_edges++;
    end
  end

  function automatic int exp_trial();
    int s;
    if (!m_busy) return 0;
    s = m_off / DIV;
    return (((m_vin >> (W - s)) << (W - s)) | (1 << (W - 1 - s))) & 32'hFFFF;
  endfunction

  always @(negedge clk) begin
    if (rst_n && !ended) begin
      check(busy == m_busy, "R5 busy", int'(busy), int'(m_busy));
      check(pd == !m_busy, "R11 pd", int'(pd), int'(!m_busy));
      check(int'(trial) == exp_trial(), "R4 trial", int'(trial), exp_trial());
      check(int'(result) == m_result, "R7 result", int'(result), m_result);
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL R5 watchdog act=running exp=done");
    finish_run();
  end

  task automatic pulse();
    @(negedge clk) cnv = 1'b1;
    @(negedge clk) cnv = 1'b0;
  endtask

  task automatic convert(input logic [W-1:0] v, input string req);
    @(negedge clk) vin = v; cnv = 1'b1;
    @(negedge clk) cnv = 1'b0;
    #1 check(busy == 1'b1, "R2 start", int'(busy), 1);
    check(trial == 16'h8000, "R3 msb", int'(trial), 16'h8000);
    repeat (TOTAL + 2) @(negedge clk);
    #1 check(result == v, req, int'(result), int'(v));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && pd == 1 && trial == 0 && result == 0, "R1 reset",
          int'({busy, pd}), 1);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    pulse();  // R9: inside hold-off window
    repeat (3) @(negedge clk);
    #1 check(busy == 0 && pd == 1, "R9 holdoff", int'(busy), 0);
    repeat (HOLD) @(negedge clk);

    convert(16'h0000, "R8 zero");
    convert(16'hFFFF, "R8 full");
    convert(16'h8000, "R4 half");
    convert(16'h1234, "R4 pat");
    convert(16'hA5A5, "R4 alt");
    convert(16'h7FFF, "R4 below half");

    // R6: extra edges during a conversion
    begin
      int len;
      @(negedge clk) vin = 16'h3C3C; cnv = 1'b1;
      @(negedge clk) cnv = 1'b0;
      len = 0;
      for (int k = 0; k < TOTAL + 4; k++) begin
        if (k == 10 || k == 60 || k == TOTAL - 3) cnv = 1'b1;
        else cnv = 1'b0;
        #1 if (busy) len++;
        @(negedge clk);
      end
      cnv = 1'b0;
      check(len == TOTAL, "R6 length", len, TOTAL);
      check(result == 16'h3C3C, "R6 result", int'(result), 16'h3C3C);
    end

    // R10: level held high across the end of a conversion
    @(negedge clk) vin = 16'h0F0F; cnv = 1'b1;
    repeat (3 * TOTAL) @(negedge clk);
    #1 check(busy == 0, "R10 no repeat", int'(busy), 0);
    check(result == 16'h0F0F, "R10 result", int'(result), 16'h0F0F);
    cnv = 1'b0;
    repeat (4) @(negedge clk);
    convert(16'h0001, "R8 lsb");
    repeat (5) @(negedge clk);
    check(pd == 1 && result == 16'h0001, "R7 hold idle", int'(result), 1);
    finish_run();
  end
endmodule